// File: doc/BRIEF.md
# CEC Receive Frame Buffer Manager

This block sits behind a CEC line receiver that has already turned the bus waveform into bytes. It captures each incoming frame, which is one header byte plus optional data bytes, into one of several fixed-size frame slots. It then tags every filled slot with a small age stamp. The host scans the stamps and reads the slot with the smallest nonzero stamp first, so messages are consumed in arrival order without any FIFO pointers.

A mode input selects between a single-slot arrangement and a three-slot arrangement. In single-slot mode, reception is blocked while the one slot is occupied. Each slot has an interrupt mask bit and a self-clearing clear strobe. The host reads stored bytes through a combinational read port addressed by slot and byte index. Frames that arrive with no free slot are dropped and recorded in a sticky overflow flag. Frames that are too long or flagged as bad are also dropped.

Top module: `cec_rx_frame_store`

## Requirements
- R1: Each slot stores up to 16 bytes. Byte k of a frame (k = 0 for the header) is returned on `rd_data` when `rd_buf` selects the slot and `rd_idx` = k, in the same cycle and with no clock edge in between.
- R2: When a frame is accepted, the slot's length field (5 bits, at `buf_len[5*i +: 5]` for slot i) equals the number of bytes received, including the header.
- R3: Stamps are 2 bits wide, at `buf_stamp[2*i +: 2]` for slot i. An empty slot reads 0, and after reset every stamp is 0. An accepted frame gets a stamp equal to the number of slots still occupied plus one, giving 1, 2 and 3 in arrival order.
- R4: A 1 on `clr_strobe[i]` sets slot i's stamp to 0 and clears its ready bit. Every other occupied slot whose stamp is larger is reduced by one for each slot cleared below it. A 0 on the strobe changes nothing.
- R5: A new frame is placed in the lowest-indexed enabled slot whose stamp is 0.
- R6: With `mode_multi` = 0 only slot 0 is enabled. While slot 0 is occupied, further frames are dropped and set the overflow flag. After slot 0 is cleared, the next frame is accepted into slot 0.
- R7: On acceptance, slot i's ready bit `rdy_status[i]` is set only if `irq_mask[i]` is 1. `irq` is the OR of all ready bits.
- R8: A frame start with no enabled empty slot drops the frame, leaves all stamps unchanged and sets `ovf_flag`. The flag stays set until a 1 on `ovf_clr`.
- R9: A frame of more than 16 bytes, a frame of zero bytes, or a frame whose end arrives with `frm_err` = 1 is dropped. Its target slot keeps stamp 0 and its ready bit stays 0.
- R10: Stamp, length and ready bit for an accepted frame change at the clock edge that samples `frm_end` and are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_multi | input | 1 | 1: three slots enabled, 0: slot 0 only |
| frm_start | input | 1 | Start of an incoming frame |
| byte_vld | input | 1 | `byte_data` holds the next frame byte |
| byte_data | input | 8 | Received byte |
| frm_end | input | 1 | End of the incoming frame |
| frm_err | input | 1 | Frame is bad; sampled together with `frm_end` |
| irq_mask | input | 3 | Per-slot interrupt enables |
| clr_strobe | input | 3 | Per-slot one-cycle release strobes |
| ovf_clr | input | 1 | Clears the overflow flag |
| rd_buf | input | 2 | Read port slot select |
| rd_idx | input | 4 | Read port byte index |
| rd_data | output | 8 | Stored byte at the selected slot and index |
| buf_len | output | 15 | Packed 5-bit byte counts, one per slot |
| buf_stamp | output | 6 | Packed 2-bit age stamps, one per slot |
| rdy_status | output | 3 | Per-slot ready bits |
| irq | output | 1 | Interrupt, OR of the ready bits |
| ovf_flag | output | 1 | Sticky dropped-frame flag |

## Verification
The assertions assume a well-formed byte stream. `frm_start`, `byte_vld` and `frm_end` are never high in the same cycle, and every byte and end strobe follows a start. They also assume the clear strobes last exactly one cycle and that `mode_multi` changes only while no frame is in flight. The stimulus drives frames only through a task that raises these strobes one at a time on separate cycles, pulses the clear inputs for one cycle, and changes the mode between frames.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_MULTI  = 1'b1
  } buf_mode_e;

  // bits needed to index n items (at least one)
  function automatic int idx_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // bits needed to count from 0 up to n inclusive
  function automatic int cnt_bits(int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cec_rx_capture.sv
module cec_rx_capture import cec_rx_pkg::*; #(
  parameter int NUM_BUF     = 3,
  parameter int FRAME_BYTES = 16,
  parameter int BYTE_W      = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              frm_start,
  input  logic                              byte_vld,
  input  logic [BYTE_W-1:0]                 byte_data,
  input  logic                              frm_end,
  input  logic                              frm_err,
  input  logic [NUM_BUF-1:0]                free_mask,
  output logic                              wr_en,
  output logic [idx_bits(NUM_BUF)-1:0]      wr_buf,
  output logic [idx_bits(FRAME_BYTES)-1:0]  wr_idx,
  output logic [BYTE_W-1:0]                 wr_data,
  output logic                              commit,
  output logic [cnt_bits(FRAME_BYTES)-1:0]  commit_len,
  output logic                              start_blocked
);
  localparam int BUF_W = idx_bits(NUM_BUF);
  localparam int IDX_W = idx_bits(FRAME_BYTES);
  localparam int CNT_W = cnt_bits(FRAME_BYTES);

  logic             act_q, act_d, drop_q, drop_d, bad_q, bad_d;
  logic [BUF_W-1:0] tgt_q, tgt_d, tgt_pick;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             found, full_q;

  assign full_q = (cnt_q == CNT_W'(FRAME_BYTES));

  always_comb begin
    tgt_pick = '0;
    found    = 1'b0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (free_mask[i]) begin
        tgt_pick = BUF_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    act_d  = act_q;
    drop_d = drop_q;
    bad_d  = bad_q;
    tgt_d  = tgt_q;
    cnt_d  = cnt_q;
    if (frm_start) begin
      act_d  = 1'b1;
      drop_d = ~found;
      bad_d  = 1'b0;
      tgt_d  = tgt_pick;
      cnt_d  = '0;
    end else if (act_q && byte_vld) begin
      if (full_q) bad_d = 1'b1;
      else        cnt_d = cnt_q + 1'b1;
    end else if (act_q && frm_end) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      drop_q <= 1'b0;
      bad_q  <= 1'b0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      drop_q <= drop_d;
      bad_q  <= bad_d;
      tgt_q  <= tgt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wr_en         = act_q & byte_vld & ~frm_start & ~drop_q & ~full_q;
  assign wr_buf        = tgt_q;
  assign wr_idx        = cnt_q[IDX_W-1:0];
  assign wr_data       = byte_data;
  assign commit        = act_q & frm_end & ~frm_start & ~byte_vld & ~drop_q
                       & ~bad_q & ~frm_err & (cnt_q != '0);
  assign commit_len    = cnt_q;
  assign start_blocked = frm_start & ~found;

  // R9
  commit_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_len != '0) && (commit_len <= CNT_W'(FRAME_BYTES)));
  // R8
  blocked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && free_mask == '0) |=> !wr_en && !commit);

endmodule

// File: rtl/cec_rx_slot.sv
module cec_rx_slot import cec_rx_pkg::*; #(
  parameter int FRAME_BYTES = 16,
  parameter int BYTE_W      = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [idx_bits(FRAME_BYTES)-1:0]  wr_idx,
  input  logic [BYTE_W-1:0]                 wr_data,
  input  logic                              commit,
  input  logic [cnt_bits(FRAME_BYTES)-1:0]  commit_len,
  input  logic [idx_bits(FRAME_BYTES)-1:0]  rd_idx,
  output logic [BYTE_W-1:0]                 rd_data,
  output logic [cnt_bits(FRAME_BYTES)-1:0]  len
);
  localparam int CNT_W = cnt_bits(FRAME_BYTES);

  logic [BYTE_W-1:0] mem_q [FRAME_BYTES];
  logic [CNT_W-1:0]  len_q, len_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  always_comb len_d = commit ? commit_len : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  assign rd_data = mem_q[rd_idx];
  assign len     = len_q;

endmodule

// File: rtl/cec_rx_age.sv
module cec_rx_age import cec_rx_pkg::*; #(
  parameter int NUM_BUF = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_BUF-1:0]                    clr,
  input  logic                                  commit,
  input  logic [idx_bits(NUM_BUF)-1:0]          commit_buf,
  input  logic [NUM_BUF-1:0]                    irq_mask,
  output logic [NUM_BUF*cnt_bits(NUM_BUF)-1:0]  stamp_flat,
  output logic [NUM_BUF-1:0]                    rdy
);
  localparam int BUF_W = idx_bits(NUM_BUF);
  localparam int ST_W  = cnt_bits(NUM_BUF);

  logic [ST_W-1:0]    st_q [NUM_BUF];
  logic [ST_W-1:0]    st_d [NUM_BUF];
  logic [NUM_BUF-1:0] rdy_q, rdy_d;

  always_comb begin
    int surv;
    surv = 0;
    for (int i = 0; i < NUM_BUF; i++) begin
      int dec;
      dec = 0;
      for (int j = 0; j < NUM_BUF; j++) begin
        if (clr[j] && st_q[j] != '0 && st_q[j] < st_q[i]) dec++;
      end
      st_d[i]  = clr[i] ? '0 : st_q[i] - ST_W'(dec);
      rdy_d[i] = clr[i] ? 1'b0 : rdy_q[i];
      if (st_d[i] != '0) surv++;
    end
    for (int i = 0; i < NUM_BUF; i++) begin
      if (commit && commit_buf == BUF_W'(i)) begin
        st_d[i]  = ST_W'(surv + 1);
        rdy_d[i] = irq_mask[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BUF; i++) st_q[i] <= '0;
      rdy_q <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) st_q[i] <= st_d[i];
      rdy_q <= rdy_d;
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_out
    assign stamp_flat[g*ST_W +: ST_W] = st_q[g];

    // R4
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !(commit && commit_buf == BUF_W'(g))) |=> (st_q[g] == '0) && !rdy_q[g]);
    // R7
    rdy_needs_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q[g] |-> (st_q[g] != '0));
    // R3
    commit_stamps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && commit_buf == BUF_W'(g)) |=> (st_q[g] != '0));
  end

  assign rdy = rdy_q;

endmodule

// File: rtl/cec_rx_frame_store.sv
module cec_rx_frame_store import cec_rx_pkg::*; #(
  parameter int NUM_BUF     = 3,
  parameter int FRAME_BYTES = 16,
  parameter int BYTE_W      = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       mode_multi,
  input  logic                                       frm_start,
  input  logic                                       byte_vld,
  input  logic [BYTE_W-1:0]                          byte_data,
  input  logic                                       frm_end,
  input  logic                                       frm_err,
  input  logic [NUM_BUF-1:0]                         irq_mask,
  input  logic [NUM_BUF-1:0]                         clr_strobe,
  input  logic                                       ovf_clr,
  input  logic [idx_bits(NUM_BUF)-1:0]               rd_buf,
  input  logic [idx_bits(FRAME_BYTES)-1:0]           rd_idx,
  output logic [BYTE_W-1:0]                          rd_data,
  output logic [NUM_BUF*cnt_bits(FRAME_BYTES)-1:0]   buf_len,
  output logic [NUM_BUF*cnt_bits(NUM_BUF)-1:0]       buf_stamp,
  output logic [NUM_BUF-1:0]                         rdy_status,
  output logic                                       irq,
  output logic                                       ovf_flag
);
  localparam int BUF_W = idx_bits(NUM_BUF);
  localparam int IDX_W = idx_bits(FRAME_BYTES);
  localparam int CNT_W = cnt_bits(FRAME_BYTES);
  localparam int ST_W  = cnt_bits(NUM_BUF);

  buf_mode_e          mode;
  logic [NUM_BUF-1:0] enabled, free_mask;
  logic               wr_en, commit, start_blocked;
  logic [BUF_W-1:0]   wr_buf;
  logic [IDX_W-1:0]   wr_idx;
  logic [BYTE_W-1:0]  wr_data;
  logic [CNT_W-1:0]   commit_len;
  logic [BYTE_W-1:0]  slot_rd [NUM_BUF];
  logic               ovf_q, ovf_d;

  assign mode = buf_mode_e'(mode_multi);

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    assign enabled[g]   = (mode == MODE_MULTI) || (g == 0);
    assign free_mask[g] = enabled[g] && (buf_stamp[g*ST_W +: ST_W] == '0);

    cec_rx_slot #(.FRAME_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en && wr_buf == BUF_W'(g)),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .commit     (commit && wr_buf == BUF_W'(g)),
      .commit_len (commit_len),
      .rd_idx     (rd_idx),
      .rd_data    (slot_rd[g]),
      .len        (buf_len[g*CNT_W +: CNT_W])
    );
  end

  cec_rx_capture #(.NUM_BUF(NUM_BUF), .FRAME_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W)) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .frm_start     (frm_start),
    .byte_vld      (byte_vld),
    .byte_data     (byte_data),
    .frm_end       (frm_end),
    .frm_err       (frm_err),
    .free_mask     (free_mask),
    .wr_en         (wr_en),
    .wr_buf        (wr_buf),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .commit        (commit),
    .commit_len    (commit_len),
    .start_blocked (start_blocked)
  );

  cec_rx_age #(.NUM_BUF(NUM_BUF)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr_strobe),
    .commit     (commit),
    .commit_buf (wr_buf),
    .irq_mask   (irq_mask),
    .stamp_flat (buf_stamp),
    .rdy        (rdy_status)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (rd_buf == BUF_W'(i)) rd_data = slot_rd[i];
    end
  end

  always_comb ovf_d = start_blocked ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf_flag = ovf_q;
  assign irq      = |rdy_status;

  // R6
  single_mode_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !mode_multi) |-> (wr_buf == '0));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

endmodule

// File: tb/sim_cec_rx_frame_store.sv
`timescale 1ns/1ps
module sim_cec_rx_frame_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_multi = 1'b1;
  logic        frm_start = 1'b0, byte_vld = 1'b0, frm_end = 1'b0, frm_err = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [2:0]  irq_mask = 3'b111, clr_strobe = '0;
  logic        ovf_clr = 1'b0;
  logic [1:0]  rd_buf = '0;
  logic [3:0]  rd_idx = '0;
  logic [7:0]  rd_data;
  logic [14:0] buf_len;
  logic [5:0]  buf_stamp;
  logic [2:0]  rdy_status;
  logic        irq, ovf_flag;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cec_rx_frame_store u0 (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .frm_start(frm_start),
    .byte_vld(byte_vld), .byte_data(byte_data), .frm_end(frm_end), .frm_err(frm_err),
    .irq_mask(irq_mask), .clr_strobe(clr_strobe), .ovf_clr(ovf_clr),
    .rd_buf(rd_buf), .rd_idx(rd_idx), .rd_data(rd_data), .buf_len(buf_len),
    .buf_stamp(buf_stamp), .rdy_status(rdy_status), .irq(irq), .ovf_flag(ovf_flag)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int stamp_of(int i);
    return int'(buf_stamp[2*i +: 2]);
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_st[3], m_rdy[3], m_len[3];
  bit m_ovf, m_act, m_drop;
  int m_tgt;
  byte unsigned m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_st[i]) begin m_st[i] = 0; m_rdy[i] = 0; m_len[i] = 0; end
      m_ovf = 0; m_act = 0; m_drop = 0; m_tgt = 0; m_q.delete();
    end else begin
      bit take, ovf_set;
      int old[3];
      int live;
      take = 0; ovf_set = 0;
      if (frm_start) begin
        int limit;
        limit = mode_multi ? 3 : 1;
        m_tgt = -1;
        for (int i = 0; i < limit; i++) if (m_tgt < 0 && m_st[i] == 0) m_tgt = i;
        m_act = 1; m_drop = (m_tgt < 0); m_q.delete();
        if (m_drop) ovf_set = 1;
      end else if (m_act && byte_vld) begin
        m_q.push_back(byte_data);
      end else if (m_act && frm_end) begin
        m_act = 0;
        if (!m_drop && !frm_err && m_q.size() >= 1 && m_q.size() <= 16) take = 1;
      end
      foreach (old[i]) old[i] = m_st[i];
      for (int i = 0; i < 3; i++) begin
        if (clr_strobe[i]) begin m_st[i] = 0; m_rdy[i] = 0; end
        else begin
          int below;
          below = 0;
          for (int j = 0; j < 3; j++)
            if (clr_strobe[j] && old[j] > 0 && old[j] < old[i]) below++;
          m_st[i] = old[i] - below;
        end
      end
      if (take) begin
        live = 0;
        for (int i = 0; i < 3; i++) if (m_st[i] > 0) live++;
        m_st[m_tgt]  = live + 1;
        m_len[m_tgt] = m_q.size();
        m_rdy[m_tgt] = irq_mask[m_tgt];
      end
      if (ovf_set) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int any;
      any = 0;
      for (int i = 0; i < 3; i++) begin
        chk("R3/R4 stamp", stamp_of(i), m_st[i]);
        chk("R7 ready", int'(rdy_status[i]), m_rdy[i]);
        if (m_st[i] != 0) chk("R2 length", int'(buf_len[5*i +: 5]), m_len[i]);
        any |= m_rdy[i];
      end
      chk("R7 irq", int'(irq), any);
      chk("R8 overflow", int'(ovf_flag), int'(m_ovf));
    end
  end

  // ---------------- stimulus ----------------
  // tgt >= 0: also checks R10 timing of the stamp on that slot
  task automatic send(int n, bit err, int base, int tgt, int exp_st);
    @(negedge clk) frm_start = 1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk) begin frm_start = 0; byte_vld = 1; byte_data = 8'(base + k); end
    end
    @(negedge clk) begin frm_start = 0; byte_vld = 0; frm_end = 1; frm_err = err; end
    if (tgt >= 0) chk("R10 before end sampled", stamp_of(tgt), 0);
    @(negedge clk) begin frm_end = 0; frm_err = 0; end
    if (tgt >= 0) chk("R10 after end sampled", stamp_of(tgt), exp_st);
  endtask

  task automatic clear(logic [2:0] m);
    @(negedge clk) clr_strobe = m;
    @(negedge clk) clr_strobe = '0;
  endtask

  task automatic rd_chk(string tag, int b, int k, int exp);
    @(negedge clk) begin rd_buf = 2'(b); rd_idx = 4'(k); end
    #1 chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state R3
    for (int i = 0; i < 3; i++) chk("R3 reset stamp", stamp_of(i), 0);
    chk("R7 reset irq", int'(irq), 0);

    // three frames in arrival order: R3, R5
    send(3, 0, 8'h10, 0, 1);
    send(16, 0, 8'h20, 1, 2);
    send(5, 0, 8'h40, 2, 3);
    rd_chk("R1 slot0 header", 0, 0, 8'h10);
    rd_chk("R1 slot1 last byte", 1, 15, 8'h2F);
    rd_chk("R1 slot2 byte4", 2, 4, 8'h44);
    chk("R2 full frame length", int'(buf_len[9:5]), 16);

    // no free slot: R8
    send(2, 0, 8'h50, -1, 0);
    chk("R8 overflow set", int'(ovf_flag), 1);
    chk("R8 stamps kept", stamp_of(2), 3);
    @(negedge clk) ovf_clr = 1;
    @(negedge clk) ovf_clr = 0;
    chk("R8 overflow cleared", int'(ovf_flag), 0);

    // clear middle slot: R4, then refill: R5
    clear(3'b010);
    chk("R4 cleared slot", stamp_of(1), 0);
    chk("R4 younger slot shifts", stamp_of(2), 2);
    chk("R4 older slot kept", stamp_of(0), 1);
    send(4, 0, 8'h60, 1, 3);
    rd_chk("R5 refilled slot1", 1, 3, 8'h63);

    // drops: R9
    clear(3'b001);
    chk("R4 two shifts", stamp_of(1) * 4 + stamp_of(2), 2 * 4 + 1);
    send(17, 0, 8'h80, 0, 0);
    send(3, 1, 8'h90, 0, 0);
    send(0, 0, 8'h00, 0, 0);
    chk("R9 no ready on drop", int'(rdy_status[0]), 0);

    // masked slot: R7
    irq_mask = 3'b110;
    send(2, 0, 8'h70, 0, 3);
    chk("R7 masked ready low", int'(rdy_status[0]), 0);
    clear(3'b110);
    chk("R4 double clear", stamp_of(0), 1);
    chk("R7 irq low", int'(irq), 0);

    // single mode: R6
    clear(3'b001);
    mode_multi = 0;
    irq_mask = 3'b111;
    send(3, 0, 8'hA0, 0, 1);
    send(3, 0, 8'hB0, 1, 0);
    chk("R6 blocked sets overflow", int'(ovf_flag), 1);
    rd_chk("R6 slot0 untouched", 0, 0, 8'hA0);
    clear(3'b001);
    send(2, 0, 8'hC0, 0, 1);
    rd_chk("R6 accepted after clear", 0, 1, 8'hC1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule